// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides whether an incoming frame is kept, based only on its 48-bit destination address. The address arrives as three 16-bit words with a one-cycle strobe. Word 0 holds the first two bytes on the wire, with the first byte in its low 8 bits.

The address is compared against four exact-match entries. Entry 0 is the station's own address. Entries 1 to 3 are extra exact-match addresses, and an entry loaded with all ones is treated as unused. Multicast addresses are also looked up in a 64-bin hash table, indexed by a CRC-32 of the address.

Two mode inputs widen acceptance:
- Promiscuous mode accepts every frame.
- All-multicast mode accepts every group-addressed frame.

The decision comes out with a 16-bit status word that records why the frame was taken.

Top module: `af_rx_da_filter`

## Requirements
- R1: A strobe on `da_valid` in cycle c produces a one-cycle pulse on `res_valid` in cycle c+2. `res_accept` and `res_status` change only together with that pulse and hold their values otherwise.
- R2: While `rst_n` is low, `res_valid`, `res_accept` and `res_status` are all zero.
- R3: An address equal to an in-use exact-match entry sets status bit 2. The entry number goes in status bits 1:0. Entry i occupies `slot_words[48*i +: 48]`, as low word, middle word, high word from the least significant end. The address is compared as {`da_word2`, `da_word1`, `da_word0`}.
- R4: An entry whose three words are all 0xFFFF never produces an exact-match hit, not even for the broadcast address.
- R5: When several entries match, the lowest-numbered one is reported.
- R6: The all-ones address sets status bit 5, clears status bit 4 and is always accepted.
- R7: An address whose first byte has bit 0 set (`da_word0[0]`), and which is not broadcast, sets status bit 4.
- R8: The hash CRC is the reflected CRC-32 (polynomial 0xEDB88320, preset all ones, no final inversion), run over the six bytes least significant bit first. Byte 0 is `da_word0[7:0]` and byte 5 is `da_word2[15:8]`. The bin is CRC bits 31:26. Bin b selects hash word b>>4 (`hash_words[16*w +: 16]`) and bit 15-(b&15) within it. A set bit raises status bit 3, but only for non-broadcast multicast addresses.
- R9: With both mode inputs low, a frame is accepted only in these cases: it is broadcast, it hits an exact-match entry, or it is multicast with a hash hit.
- R10: With `promisc_en` high, every frame is accepted. The status flags are reported as in normal mode.
- R11: With `allmc_en` high, every multicast frame is accepted, while unicast frames are still filtered as in R9.
- R12: Status bits 15:6 are always zero, and bits 1:0 are zero when bit 2 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| da_valid | input | 1 | Destination address strobe |
| da_word0 | input | 16 | Address bytes 0 (low half) and 1 |
| da_word1 | input | 16 | Address bytes 2 and 3 |
| da_word2 | input | 16 | Address bytes 4 and 5 |
| promisc_en | input | 1 | Accept every frame |
| allmc_en | input | 1 | Accept every multicast frame |
| slot_words | input | 192 | Four exact-match entries, three 16-bit words each |
| hash_words | input | 64 | Multicast hash table, four 16-bit words |
| res_valid | output | 1 | Decision valid pulse |
| res_accept | output | 1 | Frame accepted |
| res_status | output | 16 | Match flags and matched entry index |

## Verification
The sweep covers several address classes:
- each exact-match entry's own address;
- the broadcast address, which is also the content of an unused entry;
- a near miss one bit away from the station address;
- a spread of generated unicast and multicast addresses.

Each address is tried under all four combinations of the mode inputs, three hash tables (mixed, empty, full) and two entry layouts. One layout duplicates an entry to show the priority order; the other gives every entry a distinct address. The empty and full tables separate a genuine hash hit from the exact-match and all-multicast paths. The mixed table exposes any error in the CRC, bin selection or bit reversal within a word. Unicast addresses under all-multicast mode show that the mode does not leak acceptance to unicast frames.

// File: rtl/af_pkg.sv
package af_pkg;

  localparam int ADDR_W     = 48;
  localparam int ST_HIT_BIT = 2;
  localparam int ST_HSH_BIT = 3;
  localparam int ST_MC_BIT  = 4;
  localparam int ST_BC_BIT  = 5;

  // Reflected CRC-32 over six bytes, bit 0 of byte 0 first, no final inversion.
  function automatic logic [31:0] crc32_le48(input logic [ADDR_W-1:0] a);
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < ADDR_W; i++) begin
      fb = c[0] ^ a[i];
      c  = c >> 1;
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    return c;
  endfunction

  // All-ones marks an exact-match entry as unused.
  function automatic logic slot_in_use(input logic [ADDR_W-1:0] e);
    return e != {ADDR_W{1'b1}};
  endfunction

endpackage

// File: rtl/af_slot_match.sv
module af_slot_match
  import af_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int IDXW  = 2
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [NSLOT*ADDR_W-1:0] slots,
  output logic                    any_hit,
  output logic [IDXW-1:0]         hit_idx
);

  logic [NSLOT-1:0] hit_vec;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [ADDR_W-1:0] ent;
    assign ent        = slots[ADDR_W*g +: ADDR_W];
    assign hit_vec[g] = slot_in_use(ent) && (ent == addr);
  end

  // Lowest-numbered hit wins: scan from the top so lower indices overwrite.
  always_comb begin
    any_hit = |hit_vec;
    hit_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (hit_vec[i]) hit_idx = IDXW'(i);
  end

endmodule

// File: rtl/af_hash_lookup.sv
module af_hash_lookup
  import af_pkg::*;
#(
  parameter int HASH_WORDS = 4,
  parameter int BINW       = $clog2(HASH_WORDS * 16)
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [HASH_WORDS*16-1:0] table_bits,
  output logic [BINW-1:0]          bin,
  output logic                     bin_set
);

  // Bit within a word is 15 - (bin & 15), i.e. the low nibble inverted.
  logic [BINW-1:0] flat_pos;

  assign bin      = BINW'(crc32_le48(addr) >> (32 - BINW));
  assign flat_pos = {bin[BINW-1:4], ~bin[3:0]};
  assign bin_set  = table_bits[flat_pos];

endmodule

// File: rtl/af_rx_da_filter.sv
module af_rx_da_filter
  import af_pkg::*;
#(
  parameter int NSLOT      = 4,
  parameter int HASH_WORDS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      da_valid,
  input  logic [15:0]               da_word0,
  input  logic [15:0]               da_word1,
  input  logic [15:0]               da_word2,
  input  logic                      promisc_en,
  input  logic                      allmc_en,
  input  logic [NSLOT*ADDR_W-1:0]   slot_words,
  input  logic [HASH_WORDS*16-1:0]  hash_words,
  output logic                      res_valid,
  output logic                      res_accept,
  output logic [15:0]               res_status
);

  localparam int IDXW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int BINW = $clog2(HASH_WORDS * 16);

  // Stage 1: capture the address.
  logic              s1_valid;
  logic [ADDR_W-1:0] s1_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_addr  <= '0;
    end else begin
      s1_valid <= da_valid;
      if (da_valid) s1_addr <= {da_word2, da_word1, da_word0};
    end
  end

  // Stage 2: classify and match.
  logic            is_bcast, is_mcast;
  logic            exact_any;
  logic [IDXW-1:0] exact_idx;
  logic [BINW-1:0] hash_bin;
  logic            hash_bit, hash_hit;
  logic            accept_d;
  logic [15:0]     status_d;

  assign is_bcast = &s1_addr;
  assign is_mcast = s1_addr[0] && !is_bcast;

  af_slot_match #(.NSLOT(NSLOT), .IDXW(IDXW)) u_slots (
    .addr    (s1_addr),
    .slots   (slot_words),
    .any_hit (exact_any),
    .hit_idx (exact_idx)
  );

  af_hash_lookup #(.HASH_WORDS(HASH_WORDS), .BINW(BINW)) u_hash (
    .addr       (s1_addr),
    .table_bits (hash_words),
    .bin        (hash_bin),
    .bin_set    (hash_bit)
  );

  assign hash_hit = is_mcast && hash_bit;
  assign accept_d = promisc_en || is_bcast || exact_any ||
                    (is_mcast && (allmc_en || hash_hit));

  always_comb begin
    status_d             = '0;
    status_d[1:0]        = 2'(exact_idx);
    status_d[ST_HIT_BIT] = exact_any;
    status_d[ST_HSH_BIT] = hash_hit;
    status_d[ST_MC_BIT]  = is_mcast;
    status_d[ST_BC_BIT]  = is_bcast;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_status <= '0;
    end else begin
      res_valid <= s1_valid;
      if (s1_valid) begin
        res_accept <= accept_d;
        res_status <= status_d;
      end
    end
  end

  // ---------------------------------------------------------------- checks
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(da_valid, 2));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_status) && $stable(res_accept)));

  p_bcast_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status[ST_BC_BIT]) |-> (res_accept && !res_status[ST_MC_BIT]));

  p_hash_mcast_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_status[ST_HSH_BIT] |-> res_status[ST_MC_BIT]);

  p_unicast_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !promisc_en && !s1_addr[0] && !exact_any) |=> !res_accept);

  p_promisc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && promisc_en) |=> res_accept);

  p_status_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_status[15:6] == '0) && (res_status[ST_HIT_BIT] || res_status[1:0] == 2'b00));

endmodule

// File: tb/tb_af_rx_da_filter.sv
`timescale 1ns/1ps
module tb_af_rx_da_filter;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         da_valid;
  logic [15:0]  da_word0, da_word1, da_word2;
  logic         promisc_en, allmc_en;
  logic [47:0]  slot_v [4];
  logic [191:0] slot_words;
  logic [63:0]  hash_v;
  logic         res_valid, res_accept;
  logic [15:0]  res_status;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  assign slot_words = {slot_v[3], slot_v[2], slot_v[1], slot_v[0]};

  af_rx_da_filter dut (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid),
    .da_word0(da_word0), .da_word1(da_word1), .da_word2(da_word2),
    .promisc_en(promisc_en), .allmc_en(allmc_en),
    .slot_words(slot_words), .hash_words(hash_v),
    .res_valid(res_valid), .res_accept(res_accept), .res_status(res_status)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // Bytewise reflected CRC, written independently of the design.
  function automatic logic [31:0] tb_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      c = c ^ {24'h0, a[8*b +: 8]};
      for (int j = 0; j < 8; j++)
        c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return c;
  endfunction

  logic       m_hit, m_mc, m_bc, m_hh, m_acc;
  logic [1:0] m_idx;

  task automatic model(input logic [47:0] a);
    int bin;
    m_bc  = (a == 48'hFFFF_FFFF_FFFF);
    m_mc  = a[0] && !m_bc;
    m_hit = 1'b0;
    m_idx = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (slot_v[i] != 48'hFFFF_FFFF_FFFF && slot_v[i] == a) begin
        m_hit = 1'b1;
        m_idx = 2'(i);
      end
    bin  = int'(tb_crc(a) >> 26);
    m_hh = m_mc && hash_v[(bin / 16) * 16 + 15 - (bin % 16)];
    m_acc = promisc_en || m_bc || m_hit || (m_mc && (allmc_en || m_hh));
  endtask

  function automatic logic [47:0] addr_at(input int k);
    logic [15:0] x;
    if (k < 4) return slot_v[k];
    if (k == 4) return 48'hFFFF_FFFF_FFFF;
    if (k == 5) return slot_v[0] ^ 48'h0100_0000_0000;
    x = 16'(k * 16'h2469);
    return {16'(k * 16'h1F3D), 16'(k * 16'h0B71) ^ 16'h55AA,
            (k % 2 == 1) ? (x | 16'h1) : (x & 16'hFFFE)};
  endfunction

  task automatic do_one(input logic [47:0] a, input int k, input int cfg);
    string st_tag, ac_tag;
    {da_word2, da_word1, da_word0} = a;
    da_valid = 1'b1;
    @(negedge clk);
    da_valid = 1'b0;
    chk("R1 no result after one cycle", {31'b0, res_valid}, 32'd0);
    @(negedge clk);
    chk("R1 result after two cycles", {31'b0, res_valid}, 32'd1);
    model(a);
    if (m_bc) st_tag = "R4/R6 broadcast status";
    else if (m_hit && cfg == 0 && k == 3) st_tag = "R5 priority status";
    else if (m_hit) st_tag = "R3 exact status";
    else if (m_mc) st_tag = "R8 hash status";
    else st_tag = "R12 miss status";
    if (promisc_en) ac_tag = "R10 promiscuous accept";
    else if (allmc_en) ac_tag = "R11 all-multicast accept";
    else ac_tag = "R9 normal accept";
    chk(st_tag, {16'h0, res_status},
        {16'h0, 10'h0, m_bc, m_mc, m_hh, m_hit, m_idx});
    chk(ac_tag, {31'b0, res_accept}, {31'b0, m_acc});
    chk("R7 multicast flag", {31'b0, res_status[4]}, {31'b0, m_mc});
    chk("R12 upper status zero", {22'h0, res_status[15:6]}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; da_valid = 1'b0;
    da_word0 = '0; da_word1 = '0; da_word2 = '0;
    promisc_en = 1'b0; allmc_en = 1'b0;
    hash_v = '0;
    slot_v[0] = {16'h6655, 16'h4433, 16'h2210};
    slot_v[1] = {16'hBEEF, 16'h5E00, 16'h0301};
    slot_v[2] = 48'hFFFF_FFFF_FFFF;
    slot_v[3] = slot_v[1];
    repeat (3) @(negedge clk);
    chk("R2 reset valid", {31'b0, res_valid}, 32'd0);
    chk("R2 reset accept", {31'b0, res_accept}, 32'd0);
    chk("R2 reset status", {16'h0, res_status}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int cfg = 0; cfg < 2; cfg++) begin
      if (cfg == 1) slot_v[3] = {16'h0A0B, 16'h0C0D, 16'h0E02};
      for (int h = 0; h < 3; h++) begin
        hash_v = (h == 0) ? 64'hA5C3_0F0F_5AA5_3C96 :
                 (h == 1) ? 64'h0 : 64'hFFFF_FFFF_FFFF_FFFF;
        for (int m = 0; m < 4; m++) begin
          promisc_en = m[0];
          allmc_en   = m[1];
          for (int k = 0; k < 48; k++) do_one(addr_at(k), k, cfg);
        end
      end
    end
    // Outputs hold after the pulse.
    @(negedge clk);
    chk("R1 valid drops", {31'b0, res_valid}, 32'd0);
    chk("R1 accept holds", {31'b0, res_accept}, {31'b0, m_acc});
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule